// File: doc/BRIEF.md
# EEPROM Program Sequencer with Write Protection

This block sits behind the serial instruction decoder of a small word-organised non-volatile store. The decoder hands it each completed instruction as a one-clock request carrying an operation code, a word address and a data word. Enable and disable commands act at once on a protection latch. The four programming operations (single-word write, fill-all, single-word erase, erase-all) are held as a pending request. Nothing happens to them until chip select falls.

On that falling edge the pending request is checked against the protection latch and the supply-good input. If both pass, a self-timed programming cycle starts. Its length is a parameter counted in system clocks. When the cycle ends, the register-file array is updated in a single clock. While the cycle runs, and after it ends, raising chip select puts a ready/busy flag on the serial data output: low means busy and high means ready. A rising serial clock seen with chip select and data-in both high removes the flag and releases the output. All of `cs`, `sk` and `di` are sampled on `clk`, so each edge of them is detected one clock after it appears at the port. The array is read through a separate combinational port.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset the protection latch is clear, `do_oe` is 0 and every array word reads all ones.
- R2: A request with `req_op` = 1 sets the protection latch, and `req_op` = 2 clears it. Neither one changes array contents or the read port.
- R3: A programming request (`req_op` 3..6) starts a cycle only if the latch is set and `vcc_ok` is 1 on the clock where chip select is seen falling. A request that fails this check starts no cycle, leaves the array unchanged, and keeps `do_oe` at 0 while chip select is high.
- R4: The cycle starts on the clock edge where `cs` is sampled low after having been sampled high on the previous edge, with a request pending. The block then stays busy for exactly `PROG_CYCLES` clocks.
- R5: After a cycle has started, `do_oe` equals `cs`, and `do_o` is 0 while busy and 1 once finished.
- R6: A write (`req_op` = 3) leaves the addressed word equal to `req_data`.
- R7: A fill-all (`req_op` = 4) leaves every word equal to `req_data`, whatever the address.
- R8: An erase (`req_op` = 5) sets the addressed word to all ones. An erase-all (`req_op` = 6) sets every word to all ones.
- R9: An `sk` rising edge sampled while `cs` and `di` are both 1 clears the status display, so `do_oe` is 0 from the next clock.
- R10: Programming requests that arrive while a cycle is busy are ignored and change neither the running operation nor the array afterwards.
- R11: The array changes on the same clock edge at which busy ends, and `rd_data` shows `rd_addr`'s word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, sampled on clk |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in, sampled on clk |
| req_valid | input | 1 | One-clock strobe for a decoded instruction |
| req_op | input | 3 | 1 enable, 2 disable, 3 write, 4 fill-all, 5 erase, 6 erase-all |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Data for write and fill-all |
| vcc_ok | input | 1 | Supply-good indication |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Read port data |
| do_o | output | 1 | Ready/busy value (1 ready) |
| do_oe | output | 1 | Output enable for the status pin; 0 means high impedance |

## Verification
The bench checks requests that are refused, one because the latch is clear and one because the supply input is low. A design that ignored either gate would overwrite a word and drive the status pin. The busy window is counted clock by clock, so a timer that is off by one fails the length check. A write issued during an erase must not replace the pending operation; a design that let it through would leave a written word where the bench expects ones. The status-clear combination and the fill-all with a nonzero address are also checked: a wrong clear would leave the pin driven, and a fill that honoured the address would change only one word.

// File: rtl/eps_pkg.sv
package eps_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_WEN   = 3'd1,
      OP_WDS   = 3'd2,
      OP_WRITE = 3'd3,
      OP_WRALL = 3'd4,
      OP_ERASE = 3'd5,
      OP_ERAL  = 3'd6
   } prog_op_e;
endpackage

// File: rtl/eps_wen_latch.sv
module eps_wen_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic wen_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wen_o <= 1'b0;
      else if (set_i) wen_o <= 1'b1;
      else if (clr_i) wen_o <= 1'b0;
   end
endmodule

// File: rtl/eps_timer.sv
module eps_timer #(
   parameter int PROG_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         cnt    <= LOAD;
      end else if (busy_o) begin
         if (cnt == '0) busy_o <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign done_o = busy_o && (cnt == '0);
endmodule

// File: rtl/eps_array.sv
module eps_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic              all_i,
   input  logic              ones_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] flat;
   logic [DATA_W-1:0]       wval;

   assign wval = ones_i ? '1 : data_i;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = commit_i && (all_i || (addr_i == ADDR_W'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '1;
         else if (hit) q <= wval;
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < DEPTH; i++)
         if (rd_addr_i == ADDR_W'(i)) rd_data_o = flat[i*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sk,
   input  logic              di,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              vcc_ok,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              do_o,
   output logic              do_oe
);
   import eps_pkg::*;

   initial begin : param_chk
      assert (PROG_CYCLES >= 2) else $error("PROG_CYCLES must be at least 2");
      assert (ADDR_W >= 1 && ADDR_W <= 12) else $error("ADDR_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic              cs_q, sk_q;
   logic              cs_fall, sk_rise, clr_hit;
   logic              is_prog, wen_q, busy, done, start;
   logic              pend_vld, show;
   prog_op_e          pend_op;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_data;
   logic              op_all, op_ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         sk_q <= 1'b0;
      end else begin
         cs_q <= cs;
         sk_q <= sk;
      end
   end

   assign cs_fall = cs_q && !cs;
   assign sk_rise = !sk_q && sk;
   assign clr_hit = sk_rise && cs && di;
   assign is_prog = (req_op == OP_WRITE) || (req_op == OP_WRALL) ||
                    (req_op == OP_ERASE) || (req_op == OP_ERAL);

   eps_wen_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (req_valid && (req_op == OP_WEN)),
      .clr_i (req_valid && (req_op == OP_WDS)),
      .wen_o (wen_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_op   <= OP_NONE;
         pend_addr <= '0;
         pend_data <= '0;
      end else if (cs_fall) begin
         pend_vld  <= 1'b0;
      end else if (req_valid && is_prog && !busy) begin
         pend_vld  <= 1'b1;
         pend_op   <= prog_op_e'(req_op);
         pend_addr <= req_addr;
         pend_data <= req_data;
      end
   end

   assign start = cs_fall && pend_vld && wen_q && vcc_ok;

   eps_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .busy_o  (busy),
      .done_o  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   show <= 1'b0;
      else if (cs_fall && pend_vld) show <= start;
      else if (clr_hit)             show <= 1'b0;
   end

   assign op_all  = (pend_op == OP_WRALL) || (pend_op == OP_ERAL);
   assign op_ones = (pend_op == OP_ERASE) || (pend_op == OP_ERAL);

   eps_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (done),
      .all_i     (op_all),
      .ones_i    (op_ones),
      .addr_i    (pend_addr),
      .data_i    (pend_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   assign do_oe = cs && show;
   assign do_o  = do_oe && !busy;
endmodule

// File: rtl/eps_chk.sv
module eps_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              sk,
   input logic              di,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic              vcc_ok,
   input logic              wen_q,
   input logic              busy,
   input logic              done,
   input logic              pend_vld,
   input logic [2:0]        pend_op,
   input logic [ADDR_W-1:0] pend_addr,
   input logic [DATA_W-1:0] pend_data,
   input logic              show
);
   // R2
   wen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd1) |=> wen_q);
   // R2
   wen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2) |=> !wen_q);
   // R3
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs) && !cs && pend_vld && !(wen_q && vcc_ok)) |=> !busy);
   // R4
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!$past(cs) && $past(cs, 2)));
   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R9
   status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sk) && sk && cs && di) |=> !show);
   // R10
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pend_op) && $stable(pend_addr) && $stable(pend_data)));
endmodule

bind eeprom_prog_seq eps_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .sk        (sk),
   .di        (di),
   .req_valid (req_valid),
   .req_op    (req_op),
   .vcc_ok    (vcc_ok),
   .wen_q     (wen_q),
   .busy      (busy),
   .done      (done),
   .pend_vld  (pend_vld),
   .pend_op   (pend_op),
   .pend_addr (pend_addr),
   .pend_data (pend_data),
   .show      (show)
);

// File: tb/eeprom_prog_seq_tb.sv
module eeprom_prog_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int PC = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          vcc_ok = 1'b1;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          do_o, do_oe;

   int checks = 0;
   int errors = 0;
   bit live = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_data(req_data), .vcc_ok(vcc_ok), .rd_addr(rd_addr),
      .rd_data(rd_data), .do_o(do_o), .do_oe(do_oe)
   );

   // behavioural reference
   logic [DW-1:0] m_mem [0:(1<<AW)-1];
   int            m_left;
   bit            m_wen, m_show, m_pv, m_csq, m_skq;
   int            m_op;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = '1;
         m_left = 0; m_wen = 0; m_show = 0; m_pv = 0; m_csq = 0; m_skq = 0;
         m_op = 0; m_addr = '0; m_data = '0;
      end else begin
         bit fall, busy_before, wen_before;
         fall = m_csq && !cs;
         busy_before = (m_left > 0);
         wen_before = m_wen;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
               if (m_op == 4 || m_op == 6) begin
                  foreach (m_mem[i]) m_mem[i] = (m_op == 6) ? '1 : m_data;
               end else m_mem[m_addr] = (m_op == 5) ? '1 : m_data;
            end
         end
         if (fall) begin
            if (m_pv) begin
               m_show = wen_before && vcc_ok;
               if (m_show) m_left = PC;
            end
            m_pv = 0;
         end else if (!m_skq && sk && cs && di) m_show = 0;
         if (req_valid) begin
            if (req_op == 3'd1) m_wen = 1;
            else if (req_op == 3'd2) m_wen = 0;
            else if (req_op >= 3'd3 && req_op <= 3'd6 && !busy_before && !fall) begin
               m_pv = 1; m_op = int'(req_op); m_addr = req_addr; m_data = req_data;
            end
         end
         m_csq = cs; m_skq = sk;
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      if (live && !finished) begin
         bit e_oe, e_do;
         e_oe = cs && m_show;
         e_do = e_oe && (m_left == 0);
         checks++;
         if (do_oe !== e_oe) begin
            errors++; $display("FAIL R3/R5 do_oe actual=%0b expected=%0b t=%0t", do_oe, e_oe, $time);
         end
         checks++;
         if (do_o !== e_do) begin
            errors++; $display("FAIL R5 do_o actual=%0b expected=%0b t=%0t", do_o, e_do, $time);
         end
         checks++;
         if (rd_data !== m_mem[rd_addr]) begin
            errors++; $display("FAIL R11 rd_data actual=%h expected=%h t=%0t", rd_data, m_mem[rd_addr], $time);
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
      req_valid = 1; req_op = op; req_addr = a; req_data = d;
      tick();
      req_valid = 0; req_op = 3'd0;
      tick();
   endtask

   task automatic drop_cs();
      cs = 0; tick();
      cs = 1; tick();
   endtask

   task automatic wait_ready(output int busy_n);
      busy_n = 0;
      while (do_oe && !do_o && busy_n < 1000) begin
         busy_n++;
         tick();
      end
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1; checks++; errors++;
         $display("FAIL R4 watchdog actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      int n;
      logic [DW-1:0] v;
      tick(3);
      rst_n = 1; tick();
      live = 1;
      // R1
      rd(8'd0, v);   check("R1 reset word0", v, 16'hFFFF);
      rd(8'd255, v); check("R1 reset word255", v, 16'hFFFF);
      check("R1 do_oe reset", do_oe, 0);
      cs = 1; tick();
      // R3 latch clear blocks write
      issue(3'd3, 8'd5, 16'h1111);
      drop_cs();
      check("R3 no status when latch clear", do_oe, 0);
      tick(PC + 2);
      rd(8'd5, v); check("R3 latch clear word unchanged", v, 16'hFFFF);
      // R2 enable, R6 write, R4 length, R5 status
      issue(3'd1, 8'd0, 16'h0);
      issue(3'd3, 8'd5, 16'hA5C3);
      drop_cs();
      check("R5 busy shown", {do_oe, do_o}, 2'b10);
      wait_ready(n);
      check("R4 busy clocks seen with cs high", n, PC - 1);
      check("R5 ready shown", {do_oe, do_o}, 2'b11);
      rd(8'd5, v); check("R6 written word", v, 16'hA5C3);
      // R9 clear status
      di = 1; sk = 1; tick();
      check("R9 status cleared", do_oe, 0);
      sk = 0; di = 0; tick();
      // R3 supply low blocks
      vcc_ok = 0;
      issue(3'd3, 8'd7, 16'h0F0F);
      drop_cs();
      check("R3 no status when supply low", do_oe, 0);
      vcc_ok = 1;
      tick(PC + 2);
      rd(8'd7, v); check("R3 supply low word unchanged", v, 16'hFFFF);
      // R8 erase, R10 request during busy ignored
      issue(3'd5, 8'd5, 16'h0);
      drop_cs();
      issue(3'd3, 8'd6, 16'h1234);
      wait_ready(n);
      rd(8'd5, v); check("R8 erased word", v, 16'hFFFF);
      rd(8'd6, v); check("R10 write during busy ignored", v, 16'hFFFF);
      drop_cs();
      tick(PC + 2);
      rd(8'd6, v); check("R10 no deferred write", v, 16'hFFFF);
      // R7 fill-all with nonzero address
      issue(3'd4, 8'd9, 16'h5AA5);
      drop_cs();
      wait_ready(n);
      rd(8'd0, v);   check("R7 fill word0", v, 16'h5AA5);
      rd(8'd9, v);   check("R7 fill word9", v, 16'h5AA5);
      rd(8'd255, v); check("R7 fill word255", v, 16'h5AA5);
      // R2 disable blocks further writes, reads unaffected
      issue(3'd2, 8'd0, 16'h0);
      rd(8'd3, v); check("R2 read unaffected by disable", v, 16'h5AA5);
      issue(3'd3, 8'd3, 16'h0000);
      drop_cs();
      tick(PC + 2);
      rd(8'd3, v); check("R2 disabled write blocked", v, 16'h5AA5);
      // R8 erase-all
      issue(3'd1, 8'd0, 16'h0);
      issue(3'd6, 8'd0, 16'h0);
      drop_cs();
      wait_ready(n);
      rd(8'd0, v);   check("R8 erase-all word0", v, 16'hFFFF);
      rd(8'd128, v); check("R8 erase-all word128", v, 16'hFFFF);
      tick(2);
      finished = 1;
      summary();
   end
endmodule